// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits on the device side of a synchronous DRAM command bus. On every rising clock it samples the chip select, the three command strobes, the clock enable, the bank address and address bit 10. It turns each cycle into a single command code. It also keeps an idle or active flag for every bank and a device mode: normal, power-down, clock suspend or self refresh.

The decoder compares the current clock-enable sample with the previous one. When clock enable is dropped with no burst in flight, the device enters power-down. When it is dropped while a burst is running, the device enters clock suspend. Refresh pins with clock enable dropped mean self-refresh entry. A small burst tracker runs alongside the decoder. It follows the read or write burst of a fixed length, so that the suspend case can be detected and an auto-precharge can close its bank when the burst ends.

The decoded command, the illegal flag, the bank vector and the mode are all registered. Each one is updated at the same edge that samples the pins.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Command codes on `cmd_o` are 0 deselect, 1 no-op, 2 activate, 3 precharge one bank, 4 precharge all, 5 write, 6 write with auto-precharge, 7 read, 8 read with auto-precharge, 9 mode register set, 10 burst stop, 11 auto refresh, 12 self-refresh entry, 13 power-down entry, 14 clock-suspend entry and 15 low-power exit. In normal mode with `cke_i` high, a high `cs_ni` gives code 0 whatever the strobes are, and the pins {ras,cas,we} = 111 give code 1. After reset, `cmd_o`=0, `bank_active_o`=0, `mode_o`=0 and `illegal_o`=0. All outputs are updated at the edge that samples the pins.
- R2: Pins {ras,cas,we}=011 give activate (code 2) and set bit `ba_i` of `bank_active_o`.
- R3: Pins 010 give precharge. With `a10_i` low the code is 3 and only bank `ba_i` is cleared. With `a10_i` high the code is 4 and every bank is cleared.
- R4: Pins 101 give a read and pins 100 give a write. With `a10_i` high the code is the auto-precharge variant (8 or 6). The addressed bank is then cleared at the BURST_LEN-th edge after the command's edge.
- R5: Pins 001 with `cke_i` high give auto refresh (code 11). With `cke_i` low the same pins give self-refresh entry (code 12), and `mode_o` becomes 3.
- R6: Pins 000 give mode register set (code 9). Mode register set, auto refresh and self-refresh entry raise `illegal_o` if any bank is active.
- R7: If `cke_i` drops from high to low with non-refresh pins, the result depends on the burst. With no burst running, the code is 13 and `mode_o`=1 (power-down). With a burst running, the code is 14 and `mode_o`=2 (clock suspend).
- R8: The following raise `illegal_o` for that one cycle and leave `bank_active_o` unchanged: a read or write to an idle bank, an activate to an active bank, and a burst stop (pins 110, code 10) with no burst running.
- R9: A low-power mode is left when `cke_i` is sampled high. The code is then 15, `mode_o` returns to 0, the pins of that cycle are ignored, and after self refresh the banks stay all idle.
- R10: While `cke_i` stays low in a low-power mode, the code is 0 and command pins have no effect on `bank_active_o` or `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples all pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable sample |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | BA_W | Bank address |
| a10_i | input | 1 | Address bit 10: precharge-all / auto-precharge select |
| cmd_o | output | 4 | Registered decoded command code |
| bank_active_o | output | NUM_BANKS | Per-bank active flags |
| mode_o | output | 2 | Device mode: 0 normal, 1 power-down, 2 suspend, 3 self refresh |
| illegal_o | output | 1 | Registered illegal-command flag |

## Verification
Every result is due one edge after its stimulus. The command code, the illegal flag, the bank vector and the mode all change at the edge that samples the pins. The one exception is auto-precharge, whose bank clears BURST_LEN edges after the command. The driver applies pins on the falling edge and queues the expected outputs after the next rising edge. The monitor compares them on the following falling edge. For the auto-precharge case, the expected bank vector is queued for each of the no-op cycles that follow, so that the exact edge of the close is checked.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL    = 4'd0,
    CMD_NOP      = 4'd1,
    CMD_ACT      = 4'd2,
    CMD_PRE      = 4'd3,
    CMD_PREALL   = 4'd4,
    CMD_WR       = 4'd5,
    CMD_WR_AP    = 4'd6,
    CMD_RD       = 4'd7,
    CMD_RD_AP    = 4'd8,
    CMD_MRS      = 4'd9,
    CMD_BST      = 4'd10,
    CMD_AREF     = 4'd11,
    CMD_SREF_IN  = 4'd12,
    CMD_PD_IN    = 4'd13,
    CMD_SUSP_IN  = 4'd14,
    CMD_LP_EXIT  = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_PWR_DOWN = 2'd1,
    MODE_SUSPEND  = 2'd2,
    MODE_SELF_REF = 2'd3
  } mode_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_cmd_pkg::*;
(
  input  logic cke_prev_i,
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic a10_i,
  input  logic burst_busy_i,
  output cmd_e cmd_o
);
  logic refresh_pins;
  assign refresh_pins = !cs_ni && !ras_ni && !cas_ni && we_ni;

  always_comb begin
    cmd_o = CMD_DESEL;
    if (!cke_prev_i) begin
      // low-power: only the clock enable matters
      cmd_o = cke_i ? CMD_LP_EXIT : CMD_DESEL;
    end else if (!cke_i) begin
      if (refresh_pins)      cmd_o = CMD_SREF_IN;
      else if (burst_busy_i) cmd_o = CMD_SUSP_IN;
      else                   cmd_o = CMD_PD_IN;
    end else if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111: cmd_o = CMD_NOP;
        3'b011: cmd_o = CMD_ACT;
        3'b010: cmd_o = a10_i ? CMD_PREALL : CMD_PRE;
        3'b101: cmd_o = a10_i ? CMD_RD_AP : CMD_RD;
        3'b100: cmd_o = a10_i ? CMD_WR_AP : CMD_WR;
        3'b110: cmd_o = CMD_BST;
        3'b001: cmd_o = CMD_AREF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BA_W  = $clog2(NUM_BANKS),
  localparam int unsigned CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            auto_pre_i,
  input  logic [BA_W-1:0] bank_i,
  input  logic            advance_i,
  output logic            busy_o,
  output logic            close_o,
  output logic [BA_W-1:0] close_bank_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;
  logic [BA_W-1:0]  bank_q;

  assign busy_o       = (cnt_q != '0);
  assign close_o      = advance_i && ap_q && (cnt_q == CNT_W'(1));
  assign close_bank_o = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ap_q   <= 1'b0;
      bank_q <= '0;
    end else if (start_i) begin
      cnt_q  <= CNT_W'(BURST_LEN);
      ap_q   <= auto_pre_i;
      bank_q <= bank_i;
    end else if (stop_i) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (advance_i && busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 open_i,
  input  logic                 close_i,
  input  logic                 close_all_i,
  input  logic [BA_W-1:0]      bank_i,
  input  logic                 ap_close_i,
  input  logic [BA_W-1:0]      ap_bank_i,
  output logic [NUM_BANKS-1:0] active_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, ap_hit;
    assign hit    = (bank_i == BA_W'(b));
    assign ap_hit = ap_close_i && (ap_bank_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            active_o[b] <= 1'b0;
      else if (open_i && hit)                 active_o[b] <= 1'b1;
      else if (close_all_i || ap_hit ||
               (close_i && hit))              active_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_mode_fsm.sv
module sdram_mode_fsm
  import sdram_cmd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cmd_e  cmd_i,
  input  logic  illegal_i,
  output mode_e mode_o
);
  mode_e mode_d;

  always_comb begin
    mode_d = mode_o;
    unique case (cmd_i)
      CMD_SREF_IN: if (!illegal_i) mode_d = MODE_SELF_REF;
      CMD_PD_IN:   mode_d = MODE_PWR_DOWN;
      CMD_SUSP_IN: mode_d = MODE_SUSPEND;
      CMD_LP_EXIT: mode_d = MODE_NORMAL;
      default:     mode_d = mode_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_NORMAL;
    else         mode_o <= mode_d;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_i,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic [BA_W-1:0]      ba_i,
  input  logic                 a10_i,
  output logic [3:0]           cmd_o,
  output logic [NUM_BANKS-1:0] bank_active_o,
  output logic [1:0]           mode_o,
  output logic                 illegal_o
);
  cmd_e            cmd;
  mode_e           mode_q;
  logic            cke_prev_q;
  logic            illegal;
  logic            burst_busy, ap_close, advance;
  logic [BA_W-1:0] ap_bank;
  logic            bank_open, any_open;
  logic            is_rd, is_wr, is_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_prev_q <= 1'b1;
    else         cke_prev_q <= cke_i;
  end

  sdram_cmd_decode i_decode (
    .cke_prev_i   (cke_prev_q),
    .cke_i        (cke_i),
    .cs_ni        (cs_ni),
    .ras_ni       (ras_ni),
    .cas_ni       (cas_ni),
    .we_ni        (we_ni),
    .a10_i        (a10_i),
    .burst_busy_i (burst_busy),
    .cmd_o        (cmd)
  );

  assign bank_open = bank_active_o[ba_i];
  assign any_open  = |bank_active_o;
  assign is_rd     = (cmd == CMD_RD) || (cmd == CMD_RD_AP);
  assign is_wr     = (cmd == CMD_WR) || (cmd == CMD_WR_AP);
  assign is_col    = is_rd || is_wr;

  always_comb begin
    unique case (cmd)
      CMD_ACT:                       illegal = bank_open;
      CMD_RD, CMD_RD_AP,
      CMD_WR, CMD_WR_AP:             illegal = !bank_open;
      CMD_BST:                       illegal = !burst_busy;
      CMD_MRS, CMD_AREF, CMD_SREF_IN: illegal = any_open;
      default:                       illegal = 1'b0;
    endcase
  end

  // burst position only moves on fully clocked cycles
  assign advance = cke_prev_q && cke_i && (mode_q == MODE_NORMAL);

  sdram_burst_track #(
    .NUM_BANKS (NUM_BANKS),
    .BURST_LEN (BURST_LEN)
  ) i_burst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (is_col && !illegal),
    .stop_i       ((cmd == CMD_BST) && !illegal),
    .auto_pre_i   (a10_i),
    .bank_i       (ba_i),
    .advance_i    (advance),
    .busy_o       (burst_busy),
    .close_o      (ap_close),
    .close_bank_o (ap_bank)
  );

  sdram_bank_state #(
    .NUM_BANKS (NUM_BANKS)
  ) i_banks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      ((cmd == CMD_ACT) && !illegal),
    .close_i     (cmd == CMD_PRE),
    .close_all_i (cmd == CMD_PREALL),
    .bank_i      (ba_i),
    .ap_close_i  (ap_close),
    .ap_bank_i   (ap_bank),
    .active_o    (bank_active_o)
  );

  sdram_mode_fsm i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .illegal_i (illegal),
    .mode_o    (mode_q)
  );

  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= CMD_DESEL;
      illegal_o <= 1'b0;
    end else begin
      cmd_o     <= cmd;
      illegal_o <= illegal;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [3:0]           cmd_o,
  input logic [NUM_BANKS-1:0] bank_active_o,
  input logic [1:0]           mode_o,
  input logic                 illegal_o
);
  // R3
  precharge_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PREALL) |-> (bank_active_o == '0));

  // R9
  self_ref_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_SELF_REF) |-> (bank_active_o == '0));

  // R10
  low_power_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) != MODE_NORMAL) |-> (cmd_o == CMD_DESEL || cmd_o == CMD_LP_EXIT));

  // R7
  entry_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PD_IN || cmd_o == CMD_SUSP_IN) |->
      (mode_o == ((cmd_o == CMD_PD_IN) ? MODE_PWR_DOWN : MODE_SUSPEND)));

  // R5
  sref_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_SREF_IN && !illegal_o) |-> (mode_o == MODE_SELF_REF));

  // R9
  exit_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_LP_EXIT) |-> (mode_o == MODE_NORMAL));

  // R10
  hold_banks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_DESEL && $past(mode_o) != MODE_NORMAL) |-> $stable(bank_active_o));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
  .NUM_BANKS (NUM_BANKS)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_o         (cmd_o),
  .bank_active_o (bank_active_o),
  .mode_o        (mode_o),
  .illegal_o     (illegal_o)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  // pin groups {cs,ras,cas,we}
  localparam logic [3:0] P_DES = 4'b1111, P_NOP = 4'b0111, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_BST = 4'b0110, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_XDS = 4'b1000;

  typedef struct {
    logic [3:0]    cmd;
    logic [NB-1:0] banks;
    logic [1:0]    mode;
    logic          ill;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [3:0] cmd;
  logic [NB-1:0] banks;
  logic [1:0] mode;
  logic ill;
  int checks = 0, fails = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .BURST_LEN(4)) i_sdram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10),
    .cmd_o(cmd), .bank_active_o(banks), .mode_o(mode), .illegal_o(ill));

  task automatic compare(input exp_t e);
    checks++;
    if (cmd !== e.cmd || banks !== e.banks || mode !== e.mode || ill !== e.ill) begin
      fails++;
      $display("FAIL %s: got cmd=%0d banks=%b mode=%0d ill=%b, exp cmd=%0d banks=%b mode=%0d ill=%b",
               e.tag, cmd, banks, mode, ill, e.cmd, e.banks, e.mode, e.ill);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] p, input logic [1:0] b,
                      input logic a, input logic [3:0] ec, input logic [NB-1:0] eb,
                      input logic [1:0] em, input logic ei, input string tag);
    exp_t e;
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; a10 = a;
    @(posedge clk);
    e.cmd = ec; e.banks = eb; e.mode = em; e.ill = ei; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    exp_t r;
    repeat (2) @(negedge clk);
    r.cmd = 4'd0; r.banks = '0; r.mode = 2'd0; r.ill = 1'b0; r.tag = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    step(1, P_NOP, 0, 0, 4'd1, 4'b0000, 0, 0, "R1 nop");
    step(1, P_XDS, 1, 0, 4'd0, 4'b0000, 0, 0, "R1 deselect masks strobes");
    step(1, P_MRS, 0, 0, 4'd9, 4'b0000, 0, 0, "R6 mrs idle");
    step(1, P_REF, 0, 0, 4'd11, 4'b0000, 0, 0, "R5 auto refresh");
    step(1, P_ACT, 1, 0, 4'd2, 4'b0010, 0, 0, "R2 activate b1");
    step(1, P_ACT, 1, 0, 4'd2, 4'b0010, 0, 1, "R8 activate open bank");
    step(1, P_MRS, 0, 0, 4'd9, 4'b0010, 0, 1, "R6 mrs with open bank");
    step(1, P_RD,  2, 0, 4'd7, 4'b0010, 0, 1, "R8 read idle bank");
    step(1, P_WR,  2, 0, 4'd5, 4'b0010, 0, 1, "R8 write idle bank");
    step(1, P_ACT, 3, 0, 4'd2, 4'b1010, 0, 0, "R2 activate b3");
    step(1, P_RD,  1, 0, 4'd7, 4'b1010, 0, 0, "R4 read b1");
    step(0, P_NOP, 0, 0, 4'd14, 4'b1010, 2, 0, "R7 suspend entry");
    step(0, P_PRE, 1, 1, 4'd0, 4'b1010, 2, 0, "R10 suspend hold");
    step(1, P_PRE, 1, 1, 4'd15, 4'b1010, 0, 0, "R9 suspend exit");
    step(1, P_BST, 0, 0, 4'd10, 4'b1010, 0, 0, "R8 burst stop legal");
    step(1, P_BST, 0, 0, 4'd10, 4'b1010, 0, 1, "R8 burst stop no burst");
    step(1, P_PRE, 3, 0, 4'd3, 4'b0010, 0, 0, "R3 precharge b3");
    step(1, P_RD,  1, 1, 4'd8, 4'b0010, 0, 0, "R4 read ap b1");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0010, 0, 0, "R4 ap edge1");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0010, 0, 0, "R4 ap edge2");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0010, 0, 0, "R4 ap edge3");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0000, 0, 0, "R4 ap edge4 closes");
    step(1, P_ACT, 0, 0, 4'd2, 4'b0001, 0, 0, "R2 activate b0");
    step(1, P_ACT, 2, 0, 4'd2, 4'b0101, 0, 0, "R2 activate b2");
    step(1, P_PRE, 0, 1, 4'd4, 4'b0000, 0, 0, "R3 precharge all");
    step(0, P_DES, 0, 0, 4'd13, 4'b0000, 1, 0, "R7 power-down entry");
    step(0, P_ACT, 1, 0, 4'd0, 4'b0000, 1, 0, "R10 power-down hold");
    step(1, P_ACT, 1, 0, 4'd15, 4'b0000, 0, 0, "R9 power-down exit");
    step(0, P_REF, 0, 0, 4'd12, 4'b0000, 3, 0, "R5 self-refresh entry");
    step(0, P_ACT, 2, 0, 4'd0, 4'b0000, 3, 0, "R10 self-refresh hold");
    step(1, P_ACT, 2, 0, 4'd15, 4'b0000, 0, 0, "R9 self-refresh exit");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0000, 0, 0, "R9 banks idle after exit");
    step(1, P_ACT, 0, 0, 4'd2, 4'b0001, 0, 0, "R2 activate b0 again");
    step(1, P_REF, 0, 0, 4'd11, 4'b0001, 0, 1, "R6 refresh with open bank");
    step(1, P_WR,  0, 1, 4'd6, 4'b0001, 0, 0, "R4 write ap b0");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0001, 0, 0, "R4 wr ap edge1");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0001, 0, 0, "R4 wr ap edge2");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0001, 0, 0, "R4 wr ap edge3");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0000, 0, 0, "R4 wr ap edge4 closes");
    step(1, P_NOP, 0, 0, 4'd1, 4'b0000, 0, 0, "R1 tail");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule